// File: doc/BRIEF.md
# Hot-Swap Bus Connect Sequencer

This block decides when the two-wire bus on a plug-in card (a clock line and a data line) may be joined to the same pair of lines on a live backplane. It watches logic-level samples of all four lines, an enable input and a supply-good flag. It drives three outputs: a link strobe that closes the external pass path, a boost enable for the rise-time accelerators, and a ready flag.

The block closes the link only when the backplane has just finished a transaction and both card lines read high. A transaction counts as finished on a STOP condition, or when both backplane lines have stayed high for a programmable number of clock cycles. Losing the supply or dropping enable opens the link within a few cycles. Closing it again always requires a fresh end-of-transaction condition. Every input is resynchronised to the block clock before use.

Top module: `hsb_connect_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `link_o`, `boost_o` and `ready_o` are all 0.
- R2: While the synchronised supply-good flag is 0, the block stays in lockout and its outputs stay 0, whatever the bus lines and the enable input do.
- R3: In the waiting state with enable high and both card lines high, a STOP condition on the backplane closes the link. A STOP is backplane data going from 0 to 1 while backplane clock is 1. The outputs rise on the third rising clock edge after the data line changes.
- R4: A 0-to-1 transition of backplane data while backplane clock is 0 is not a STOP and does not close the link.
- R5: The link closes once both backplane lines have been high for IDLE_CYCLES consecutive counting cycles. With stable inputs, enable arriving at edge k gives outputs rising on edge k+IDLE_CYCLES+3. The idle counter saturates at IDLE_CYCLES.
- R6: A low on either backplane line, even for a single cycle, clears the idle count, so counting restarts from zero.
- R7: Neither a STOP nor an expired idle count closes the link while either card line is low. If a card line rises after the idle count has expired, the link closes three edges later.
- R8: `link_o`, `boost_o` and `ready_o` always change together. The output triple is either all 0 or all 1.
- R9: Enable going low drops all three outputs on the third rising edge after the change, with no idle delay.
- R10: After enable returns high, the idle count starts from zero. An already idle backplane still needs the full IDLE_CYCLES window.
- R11: Supply-good going low drops all outputs within three edges. When it returns high, the block needs a fresh full idle window or a STOP before it connects again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_scl_i | input | 1 | Backplane clock line level |
| bp_sda_i | input | 1 | Backplane data line level |
| card_scl_i | input | 1 | Card clock line level |
| card_sda_i | input | 1 | Card data line level |
| enable_i | input | 1 | Connection enable, active high |
| supply_ok_i | input | 1 | Supply good (lockout released), active high |
| link_o | output | 1 | Closes the external pass path between the two buses |
| boost_o | output | 1 | Enables the rise-time accelerators |
| ready_o | output | 1 | High while the sides are joined |

## Verification
The bench times the idle window to the exact edge. The link must still be open one cycle before the limit and closed on it, so an off-by-one counter or a counter that is not cleared on entry shows up as a connect one edge early or late. It pulses a backplane line low for one cycle mid-window: a design that does not restart the count connects too early. It raises data while clock is low: a design that ignores the clock level connects at once. It holds a card line low through a STOP and a full idle window, and a design that skips the card check joins the buses anyway. It drops enable and supply while connected, and then re-enables over an already idle bus; a design that keeps stale idle credit reconnects without waiting.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_LOCKOUT = 2'd0,
    ST_WAIT    = 2'd1,
    ST_LINKED  = 2'd2
  } link_state_e;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else if (g == 0) stg[g] <= d_i;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hsb_bus_watch.sv
module hsb_bus_watch #(
  parameter int IDLE_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic count_en_i,
  output logic stop_o,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic          sda_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          both_high;

  assign both_high = scl_i & sda_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!count_en_i || !both_high) cnt_d = '0;
    else if (cnt_q != LIMIT)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      sda_q <= sda_i;
      cnt_q <= cnt_d;
    end
  end

  assign stop_o = sda_i & ~sda_q & scl_i;
  assign idle_o = (cnt_q == LIMIT);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  // R6
  low_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_i || !sda_i) |=> !idle_o);
  // R10
  idle_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(count_en_i));
endmodule

// File: rtl/hsb_link_fsm.sv
module hsb_link_fsm
  import hsb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_i,
  input  logic en_i,
  input  logic stop_i,
  input  logic idle_i,
  input  logic card_ok_i,
  output logic count_en_o,
  output logic link_o,
  output logic boost_o,
  output logic ready_o
);
  link_state_e state_q, state_d;
  logic        done;

  assign done = stop_i | idle_i;

  always_comb begin
    state_d = state_q;
    if (!supply_i) state_d = ST_LOCKOUT;
    else begin
      unique case (state_q)
        ST_LOCKOUT: state_d = ST_WAIT;
        ST_WAIT:    if (en_i && done && card_ok_i) state_d = ST_LINKED;
        ST_LINKED:  if (!en_i) state_d = ST_WAIT;
        default:    state_d = ST_LOCKOUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKOUT;
    else        state_q <= state_d;
  end

  assign count_en_o = (state_q == ST_WAIT) & en_i;
  assign link_o     = (state_q == ST_LINKED);
  assign boost_o    = (state_q == ST_LINKED);
  assign ready_o    = (state_q == ST_LINKED);

  // R2
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_i |=> !link_o);
  // R9
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !link_o);
  // R7
  card_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> $past(card_ok_i && en_i && (stop_i || idle_i)));
endmodule

// File: rtl/hsb_connect_seq.sv
module hsb_connect_seq #(
  parameter int IDLE_CYCLES = 9500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_scl_i,
  input  logic bp_sda_i,
  input  logic card_scl_i,
  input  logic card_sda_i,
  input  logic enable_i,
  input  logic supply_ok_i,
  output logic link_o,
  output logic boost_o,
  output logic ready_o
);
  logic [3:0] bus_s;
  logic [1:0] ctl_s;
  logic       stop, idle, count_en;

  hsb_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({bp_scl_i, bp_sda_i, card_scl_i, card_sda_i}),
    .q_o(bus_s)
  );

  hsb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({supply_ok_i, enable_i}),
    .q_o(ctl_s)
  );

  hsb_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
    .clk(clk), .rst_n(rst_n),
    .scl_i(bus_s[3]), .sda_i(bus_s[2]),
    .count_en_i(count_en),
    .stop_o(stop), .idle_o(idle)
  );

  hsb_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .supply_i(ctl_s[1]), .en_i(ctl_s[0]),
    .stop_i(stop), .idle_i(idle),
    .card_ok_i(bus_s[1] & bus_s[0]),
    .count_en_o(count_en),
    .link_o(link_o), .boost_o(boost_o), .ready_o(ready_o)
  );
endmodule

// File: tb/hsb_connect_seq_tb.sv
module hsb_connect_seq_tb;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic bp_scl, bp_sda, card_scl, card_sda, en, sup;
  logic link, boost, ready;

  always #2 clk = ~clk;

  hsb_connect_seq #(.IDLE_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bp_scl_i(bp_scl), .bp_sda_i(bp_sda),
    .card_scl_i(card_scl), .card_sda_i(card_sda),
    .enable_i(en), .supply_ok_i(sup),
    .link_o(link), .boost_o(boost), .ready_o(ready)
  );

  typedef struct {
    int         cyc;
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input int d, input bit on, input string tag);
    item_t it;
    int pos;
    it.cyc = cyc + d;
    it.exp = on ? 3'b111 : 3'b000;
    it.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++)
      if (q[i].cyc > it.cyc) begin pos = i; break; end
    q.insert(pos, it);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops items due now and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (it.cyc != cyc || {link, boost, ready} !== it.exp) begin
        fails++;
        $display("FAIL %s: cycle %0d got %b expected %b", it.tag, cyc,
                 {link, boost, ready}, it.exp);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    bp_scl = 1; bp_sda = 1; card_scl = 1; card_sda = 1; en = 0; sup = 0;
    wait_n(1);
    chk(1, 0, "R1 in reset");
    wait_n(3);
    rst_n = 1'b1;
    chk(2, 0, "R1 after release");
    wait_n(3);

    // R2: supply low, enable high, STOPs and idle are ignored
    en = 1;
    chk(5, 0, "R2"); chk(20, 0, "R2"); chk(39, 0, "R2");
    repeat (10) begin bp_sda = 0; wait_n(2); bp_sda = 1; wait_n(2); end
    wait_n(5);

    // R3: STOP connects after supply release
    bp_sda = 0; sup = 1;
    wait_n(30);
    chk(30, 0, "R3 no idle while data low");
    wait_n(2);
    bp_sda = 1;
    chk(2, 0, "R3 early"); chk(3, 1, "R3/R8 STOP connect");
    wait_n(10);

    // R9: enable drop
    en = 0;
    chk(2, 1, "R9 before"); chk(3, 0, "R9/R8 drop");
    wait_n(10);

    // R5/R10: idle window from re-enable
    en = 1;
    chk(N + 2, 0, "R10 idle window early"); chk(N + 3, 1, "R5 idle connect");
    wait_n(N + 10);

    // R6: one-cycle low restarts the count
    en = 0; wait_n(10);
    en = 1;
    chk(N + 3, 0, "R6 no early connect");
    chk(N + 13, 0, "R6 restarted early");
    chk(N + 14, 1, "R6 restarted connect");
    wait_n(10);
    bp_scl = 0; wait_n(1); bp_scl = 1;
    wait_n(N + 20);

    // R4: data rise with clock low is not STOP
    en = 0; bp_sda = 0; bp_scl = 0;
    wait_n(5); en = 1; wait_n(10);
    bp_sda = 1;
    chk(3, 0, "R4"); chk(8, 0, "R4");
    wait_n(10);
    bp_sda = 0; wait_n(3); bp_scl = 1; wait_n(5);
    bp_sda = 1;
    chk(3, 1, "R3 STOP after clock high");
    wait_n(10);

    // R7: card line low blocks both STOP and idle
    en = 0; card_sda = 0; bp_sda = 0;
    wait_n(5); en = 1; wait_n(5);
    bp_sda = 1;
    chk(3, 0, "R7 STOP blocked"); chk(N + 8, 0, "R7 idle blocked");
    wait_n(N + 10);
    card_sda = 1;
    chk(2, 0, "R7 early"); chk(3, 1, "R7 card high connect");
    wait_n(10);

    // R11: supply loss and return
    sup = 0;
    chk(2, 1, "R11 before"); chk(3, 0, "R11 drop");
    wait_n(10);
    bp_sda = 0; wait_n(2); bp_sda = 1;
    chk(3, 0, "R2 STOP ignored in lockout");
    wait_n(10);
    sup = 1;
    chk(N + 3, 0, "R11 fresh window early"); chk(N + 4, 1, "R11 reconnect");
    wait_n(N + 10);

    while (q.size() > 0) wait_n(1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule